// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block is a management-interface master that software drives through a small set of 32-bit registers. Software loads a target PHY address and register number into one packed register and, for a write, the 16-bit payload into another. It then writes the command register with the launch bit set and an opcode. The block runs one complete management frame on the MDC/MDIO pins and raises a busy flag for the length of that frame. For a read, it shifts the PHY's reply into a read-data register.

The frame is the classic short form: a run of ones as preamble, the start pattern, a 2-bit opcode, the 5-bit PHY and register addresses, a 2-bit turnaround and 16 data bits, all most significant bit first. MDC is the system clock divided by a parameter and stays low between frames. MDIO only changes after a falling MDC edge, and the master samples the PHY's reply on the rising edge. During a read the master releases the line for the turnaround and the data field. A frame-format bit in the mode register can be written and read back, but it does not change the frame.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register reads as zero, MDC is low and the MDIO output enable is low.
- R2: Mode register (offset 0x40) bit 8 is a long-frame select that can be written and read back. It has no effect on the frame, which is always the short form.
- R3: The address register (offset 0x44) holds the PHY address in bits [12:8] and the register number in bits [4:0]. The write-data register (offset 0x48) holds the payload in bits [15:0]. Both read back what was written, and all other bits read as zero.
- R4: Writing the command register (offset 0x50) with bit 8 set starts one frame, and bit 0 selects the opcode (0 = read, 1 = write). Bit 8 always reads as 0, and bit 0 reads back the last launched opcode. A command write with bit 8 clear starts nothing.
- R5: Command bit 16 (busy) reads as 1 from the cycle after a launch until the last frame bit ends, then returns to 0.
- R6: Each frame is 32 ones, then 01, then opcode 10 (read) or 01 (write), then the PHY address, the register number, a 2-bit turnaround and 16 data bits, each field MSB first.
- R7: For a write, the master drives every bit, with turnaround 10. The payload is the write-data register's value when the launch happened; later writes to that register do not alter the frame.
- R8: For a read, the output enable is low for both turnaround bits and all 16 data bits. The master samples MDIO on each rising MDC edge of the data field, and the 16-bit result reads at offset 0x4C once busy is clear. Writes to 0x4C are ignored.
- R9: MDC has a period of MDC_DIV system clocks (default 16) and is low while idle. MDIO and its output enable change only while MDC is low.
- R10: A launch written while busy is set is ignored: it neither starts a frame nor changes the stored opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the offset of the previous cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen at the pin |

## Verification
The assertions assume the following about the inputs. MDC_DIV is even and at least 2, reset is held for at least one clock, and mdio_i matters only during the data field of a read. They place no limit on when software may write. The stimulus holds the write strobe for exactly one clock per access and uses only the mapped offsets. The modelled PHY changes mdio_i only after a falling MDC edge, so every sampled bit has settled for half an MDC period. A launch issued during a frame is sent on purpose, so that the rule that such a launch is ignored is exercised while busy is set.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // register byte offsets (software-visible map)
  localparam logic [7:0] OFS_MODE = 8'h40;
  localparam logic [7:0] OFS_ADDR = 8'h44;
  localparam logic [7:0] OFS_WDAT = 8'h48;
  localparam logic [7:0] OFS_RDAT = 8'h4C;
  localparam logic [7:0] OFS_CMD  = 8'h50;

  // field positions
  localparam int CMD_GO_BIT   = 8;
  localparam int CMD_BUSY_BIT = 16;
  localparam int MODE_LF_BIT  = 8;
  localparam int PHY_LSB      = 8;
  localparam int FLD_W        = 5;
  localparam int PAYLOAD_W    = 16;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;

  typedef struct packed {
    logic [FLD_W-1:0]     phy;
    logic [FLD_W-1:0]     regn;
    logic [PAYLOAD_W-1:0] wdata;
    op_e                  op;
  } xfer_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);

  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = en && (cnt == CW'(HALF - 1));
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PREAMBLE = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        launch,
  input  xfer_t                       xfer,
  input  logic                        rise_stb,
  input  logic                        fall_stb,
  input  logic                        mdio_i,
  output logic                        busy,
  output logic                        is_read,
  output logic [$clog2(PREAMBLE+32)-1:0] bit_idx,
  output logic                        mdio_o,
  output logic                        mdio_oe,
  output logic                        rd_load,
  output logic [PAYLOAD_W-1:0]        rd_value
);

  localparam int FRAME_BITS = PREAMBLE + 32;
  localparam int BIDX_W     = $clog2(FRAME_BITS);
  localparam int DATA_FIRST = FRAME_BITS - PAYLOAD_W;
  localparam int REL_FIRST  = DATA_FIRST - 2;

  logic [FRAME_BITS-1:0] sh_q, oe_q;
  logic [FRAME_BITS-1:0] frame_bits, frame_oe;
  logic [PAYLOAD_W-1:0]  cap_q;
  logic                  last_bit;
  logic                  rd_op;

  assign rd_op = (xfer.op == OP_READ);

  always_comb begin
    frame_bits = {{PREAMBLE{1'b1}}, 2'b01,
                  rd_op ? 2'b10 : 2'b01,
                  xfer.phy, xfer.regn,
                  rd_op ? 2'b00 : 2'b10,
                  rd_op ? {PAYLOAD_W{1'b0}} : xfer.wdata};
    frame_oe   = rd_op ? {{REL_FIRST{1'b1}}, {(FRAME_BITS-REL_FIRST){1'b0}}}
                       : {FRAME_BITS{1'b1}};
  end

  assign last_bit = (bit_idx == BIDX_W'(FRAME_BITS - 1));
  assign rd_load  = busy && fall_stb && last_bit && is_read;
  assign rd_value = cap_q;
  assign mdio_o   = sh_q[FRAME_BITS-1];
  assign mdio_oe  = oe_q[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      is_read <= 1'b0;
      bit_idx <= '0;
      sh_q    <= '0;
      oe_q    <= '0;
      cap_q   <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      is_read <= rd_op;
      bit_idx <= '0;
      sh_q    <= frame_bits;
      oe_q    <= frame_oe;
    end else if (busy) begin
      if (rise_stb && is_read && (bit_idx >= BIDX_W'(DATA_FIRST)))
        cap_q <= {cap_q[PAYLOAD_W-2:0], mdio_i};
      if (fall_stb) begin
        if (last_bit) begin
          busy    <= 1'b0;
          bit_idx <= '0;
          sh_q    <= '0;
          oe_q    <= '0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b0};
          oe_q    <= {oe_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 busy,
  input  logic                 rd_load,
  input  logic [PAYLOAD_W-1:0] rd_value,
  output logic                 launch,
  output xfer_t                xfer
);

  logic                 lf_sel_q;
  logic [FLD_W-1:0]     phy_q, regn_q;
  logic [PAYLOAD_W-1:0] wdat_q, rdat_q;
  op_e                  op_q;
  logic                 hit_mode, hit_addr, hit_wdat, hit_cmd;
  logic [DATA_W-1:0]    rd_mux;

  assign hit_mode = bus_we && (bus_addr == ADDR_W'(OFS_MODE));
  assign hit_addr = bus_we && (bus_addr == ADDR_W'(OFS_ADDR));
  assign hit_wdat = bus_we && (bus_addr == ADDR_W'(OFS_WDAT));
  assign hit_cmd  = bus_we && (bus_addr == ADDR_W'(OFS_CMD));

  assign launch = hit_cmd && bus_wdata[CMD_GO_BIT] && !busy;
  assign xfer   = '{phy: phy_q, regn: regn_q, wdata: wdat_q,
                    op: op_e'(bus_wdata[0])};

  always_ff @(posedge clk) begin
    if (rst) begin
      lf_sel_q <= 1'b0;
      phy_q    <= '0;
      regn_q   <= '0;
      wdat_q   <= '0;
      rdat_q   <= '0;
      op_q     <= OP_READ;
    end else begin
      if (hit_mode) lf_sel_q <= bus_wdata[MODE_LF_BIT];
      if (hit_addr) begin
        phy_q  <= bus_wdata[PHY_LSB +: FLD_W];
        regn_q <= bus_wdata[FLD_W-1:0];
      end
      if (hit_wdat) wdat_q <= bus_wdata[PAYLOAD_W-1:0];
      if (launch)   op_q   <= op_e'(bus_wdata[0]);
      if (rd_load)  rdat_q <= rd_value;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_MODE): rd_mux[MODE_LF_BIT] = lf_sel_q;
      ADDR_W'(OFS_ADDR): begin
        rd_mux[PHY_LSB +: FLD_W] = phy_q;
        rd_mux[FLD_W-1:0]        = regn_q;
      end
      ADDR_W'(OFS_WDAT): rd_mux[PAYLOAD_W-1:0] = wdat_q;
      ADDR_W'(OFS_RDAT): rd_mux[PAYLOAD_W-1:0] = rdat_q;
      ADDR_W'(OFS_CMD): begin
        rd_mux[CMD_BUSY_BIT] = busy;
        rd_mux[0]            = op_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int MDC_DIV  = 16,
  parameter int PREAMBLE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam int FRAME_BITS = PREAMBLE + 32;
  localparam int BIDX_W     = $clog2(FRAME_BITS);

  logic                 launch, busy, is_read, rd_load;
  logic                 rise_stb, fall_stb;
  logic [BIDX_W-1:0]    bit_idx;
  logic [PAYLOAD_W-1:0] rd_value;
  xfer_t                xfer;

  mdio_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .rd_load(rd_load), .rd_value(rd_value), .launch(launch), .xfer(xfer)
  );

  mdio_mdc_gen #(.DIV(MDC_DIV)) u_mdc (
    .clk(clk), .rst(rst), .en(busy), .mdc(mdc),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine #(.PREAMBLE(PREAMBLE)) u_frame (
    .clk(clk), .rst(rst), .launch(launch), .xfer(xfer),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .is_read(is_read), .bit_idx(bit_idx),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_load(rd_load), .rd_value(rd_value)
  );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
  parameter int PREAMBLE = 32
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                mdc,
  input logic                                mdio_o,
  input logic                                mdio_oe,
  input logic                                busy,
  input logic                                is_read,
  input logic [$clog2(PREAMBLE+32)-1:0]      bit_idx
);

  localparam int FRAME_BITS = PREAMBLE + 32;
  localparam int BIDX_W     = $clog2(FRAME_BITS);
  localparam int REL_FIRST  = FRAME_BITS - 18;

  p_mdio_hold_r9: assert property (@(posedge clk) disable iff (rst)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  p_frame_open_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mdio_o && mdio_oe && !mdc));

  p_read_release_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && is_read && (bit_idx >= BIDX_W'(REL_FIRST))) |-> !mdio_oe);

  p_write_drive_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_read) |-> mdio_oe);

  p_busy_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(bit_idx) == BIDX_W'(FRAME_BITS - 1)));

endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(.PREAMBLE(PREAMBLE)) u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .is_read(is_read), .bit_idx(bit_idx)
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
  import mdio_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;

  always #5 clk = ~clk;

  mdio_mgmt_master dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;
  logic [63:0] q_bits[$];
  logic [63:0] q_oe[$];
  logic [15:0] phy_resp = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      bus_read(OFS_CMD, v);
      if (!v[16]) return;
    end
  endtask

  // driver: program and launch, push expected frame to the scoreboard
  task automatic launch_xfer(input bit rd, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] d);
    logic [63:0] b, o;
    bus_write(OFS_ADDR, {19'd0, phy, 3'd0, rg});
    if (!rd) bus_write(OFS_WDAT, {16'd0, d});
    b = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
         rd ? 2'b00 : 2'b10, rd ? 16'h0000 : d};
    o = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
    q_bits.push_back(b);
    q_oe.push_back(o);
    bus_write(OFS_CMD, rd ? 32'h0000_0100 : 32'h0000_0101);
  endtask

  // monitor: capture each frame bit at rising MDC and compare with the queue
  initial begin
    int          rc = 0;
    longint      last_t = 0;
    logic [63:0] got_b = '0, got_o = '0;
    forever begin
      @(posedge mdc);
      @(negedge clk);
      got_b[63-rc] = mdio_o;
      got_o[63-rc] = mdio_oe;
      if (rc > 0) chk("R9 mdc period", 64'($time - last_t), 64'd160);
      last_t = $time;
      rc++;
      if (rc == 64) begin
        if (q_bits.size() == 0) begin
          chk("R10 unexpected frame", 64'd1, 64'd0);
        end else begin
          logic [63:0] eb, eo;
          eb = q_bits.pop_front();
          eo = q_oe.pop_front();
          chk("R6 frame bits", got_b & eo, eb & eo);
          chk("R7/R8 output enable pattern", got_o, eo);
        end
        rc = 0;
      end
    end
  end

  // PHY model: drive reply bits after each falling MDC edge
  initial begin
    int fc = 0;
    forever begin
      @(negedge mdc);
      fc++;
      if (fc >= 48 && fc <= 63) mdio_i = phy_resp[63-fc];
      else mdio_i = 1'b0;
      if (fc == 64) fc = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 mdc low", 64'(mdc), 64'd0);
    chk("R1 oe low", 64'(mdio_oe), 64'd0);
    bus_read(OFS_MODE, v); chk("R1 mode reset", 64'(v), 64'd0);
    bus_read(OFS_ADDR, v); chk("R1 addr reset", 64'(v), 64'd0);
    bus_read(OFS_RDAT, v); chk("R1 rdata reset", 64'(v), 64'd0);
    bus_read(OFS_CMD, v);  chk("R1 cmd reset", 64'(v), 64'd0);

    // R2 mode bit stored, frame stays short form
    bus_write(OFS_MODE, 32'hFFFF_FFFF);
    bus_read(OFS_MODE, v); chk("R2 mode readback", 64'(v), 64'h100);

    // R3 readback of address and payload
    bus_write(OFS_ADDR, 32'hFFFF_FFFF);
    bus_read(OFS_ADDR, v); chk("R3 addr fields", 64'(v), 64'h1F1F);
    bus_write(OFS_WDAT, 32'hDEAD_A5C3);
    bus_read(OFS_WDAT, v); chk("R3 wdata field", 64'(v), 64'hA5C3);

    // R4 command with launch bit clear starts nothing
    bus_write(OFS_CMD, 32'h0000_0001);
    repeat (20) @(negedge clk);
    chk("R4 no launch mdc", 64'(mdc), 64'd0);
    bus_read(OFS_CMD, v); chk("R4 no launch busy", 64'(v), 64'd0);

    // write frame with mode bit set (R2), busy and readback (R4, R5)
    launch_xfer(1'b0, 5'h11, 5'h05, 16'hA5C3);
    bus_read(OFS_CMD, v); chk("R5 busy after launch, R4 go reads 0", 64'(v), 64'h1_0001);
    bus_write(OFS_WDAT, 32'h0000_0000);          // R7: must not alter frame
    bus_write(OFS_CMD, 32'h0000_0100);           // R10: ignored while busy
    wait_idle();
    bus_read(OFS_CMD, v); chk("R5 busy clear, R10 opcode kept", 64'(v), 64'h1);
    repeat (300) @(negedge clk);
    chk("R10 no second frame", 64'(mdc), 64'd0);
    chk("R10 scoreboard drained", 64'(q_bits.size()), 64'd0);

    // R8 reads with boundary addresses and patterns
    bus_write(OFS_MODE, 32'h0);
    phy_resp = 16'h8001;
    launch_xfer(1'b1, 5'h1F, 5'h1E, 16'h0);
    wait_idle();
    bus_read(OFS_RDAT, v); chk("R8 read data 8001", 64'(v), 64'h8001);

    phy_resp = 16'h7FFE;
    launch_xfer(1'b1, 5'h00, 5'h00, 16'h0);
    wait_idle();
    bus_read(OFS_RDAT, v); chk("R8 read data 7FFE", 64'(v), 64'h7FFE);

    bus_write(OFS_RDAT, 32'h1234_5678);
    bus_read(OFS_RDAT, v); chk("R8 rdata write ignored", 64'(v), 64'h7FFE);

    // more write patterns
    launch_xfer(1'b0, 5'h1F, 5'h1F, 16'hFFFF);
    wait_idle();
    launch_xfer(1'b0, 5'h0A, 5'h15, 16'h0001);
    wait_idle();
    bus_read(OFS_CMD, v); chk("R4 write opcode readback", 64'(v), 64'h1);
    repeat (50) @(negedge clk);
    chk("R6 all frames seen", 64'(q_bits.size()), 64'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule